// File: doc/BRIEF.md
# Interleaved Non-Overlapping Phase Generator

This block produces switching phases for a bank of interleaved switched-capacitor converter units. All of it runs from a single input clock. A rate divider makes a clock-enable "tick" once every 1, 2 or 4 input cycles. A one-hot token advances on every tick. From the token position each unit derives a 50% duty unit clock, and the unit clocks are staggered by one tick each, which is one-eighth of the unit period for eight units.

Each unit turns its unit clock into a pair of phases, A and B, using a break-before-make cell. When the unit clock changes, the phase that is high drops at once. Both phases then stay low for a programmable number of input cycles. Only after that gap does the phase that matches the unit clock rise.

A state controller can change the division select while the block runs. The new ratio is taken up only when the token wraps from the last unit back to unit 0, so a division change never cuts a running period short.

Top module: `ilv_phase_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `ph_a` and `ph_b` is 0.
- R2: In steady state, the rising edges of `ph_a` across the units occur in the cyclic order 0, 1, ..., UNITS-1, 0, and exactly one token position is active at any time.
- R3: For every unit k, `ph_a[k]` and `ph_b[k]` are never both 1 in the same cycle.
- R4: Between the fall of one phase of a pair and the rise of the other, both phases stay low for exactly D input cycles, where D is the effective dead time defined in R7.
- R5: `div_sel` maps to the ratio R as follows: 0 gives 1, 1 gives 2, and 2 or 3 give 4. In steady state, consecutive `ph_a` rises of neighbouring units are R input cycles apart, so one unit period lasts UNITS*R cycles.
- R6: After reset the ratio is 1 until the first token wrap. A new `div_sel` value is taken up only on the tick that moves the token from the last unit to unit 0. While the ratio changes with D below 2*Rmin, no phase pulse is shorter than (UNITS/2)*Rmin - D, where Rmin is the smaller of the old and new ratios.
- R7: The effective dead time D equals `dead_cyc`, except that a value of 0 is treated as 1 and values above (UNITS/2)*R - 1 are saturated to that bound. A cell samples D when it enters the gap.
- R8: In steady state, every high pulse of `ph_a` or `ph_b` lasts (UNITS/2)*R - D input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Division select (0: /1, 1: /2, 2 or 3: /4) |
| dead_cyc | input | DT_W | Requested dead time in input cycles |
| ph_a | output | UNITS | Phase A of each unit, high while its unit clock is high |
| ph_b | output | UNITS | Phase B of each unit, high while its unit clock is low |

## Verification
The checker watches several properties on every cycle. It checks that the two phases of a pair never overlap and that a phase rises only after a cycle with its partner low. It checks that the token stays one-hot, that the held ratio moves only on a wrap tick, and that the divider ticks every cycle at ratio 1.

Other behaviour can only be shown by the bench scenarios, which measure whole events across many cycles. These are the exact gap length, the pulse widths, the unit rotation order and the spacing of rises for each ratio. The same goes for dead-time saturation and the absence of runt pulses while the ratio is switched at run time.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int unsigned MAX_RATIO = 4;

  typedef enum logic [1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2
  } ratio_e;

  typedef enum logic [1:0] {
    PH_GAP = 2'd0,
    PH_A   = 2'd1,
    PH_B   = 2'd2
  } phase_st_e;

  // Map the external select code to a ratio; code 3 aliases to /4.
  function automatic ratio_e decode_sel(input logic [1:0] sel);
    case (sel)
      2'd0:    return RATIO_1;
      2'd1:    return RATIO_2;
      default: return RATIO_4;
    endcase
  endfunction

  function automatic int unsigned ratio_cycles(input ratio_e r);
    case (r)
      RATIO_1: return 1;
      RATIO_2: return 2;
      default: return 4;
    endcase
  endfunction

  // Effective dead time: at least one cycle, at most one cycle short of
  // a half unit period so each phase keeps a pulse of one cycle or more.
  function automatic int unsigned eff_dead(input int unsigned req,
                                           input int unsigned ratio,
                                           input int unsigned half_steps);
    int unsigned lo;
    int unsigned hi;
    lo = (req == 0) ? 1 : req;
    hi = half_steps * ratio - 1;
    return (lo > hi) ? hi : lo;
  endfunction

endpackage

// File: rtl/ilv_rate_div.sv
module ilv_rate_div
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wrap,
  output logic       tick,
  output ratio_e     ratio_q
);

  localparam int CNT_W = $clog2(MAX_RATIO);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(ratio_cycles(ratio_q) - 1);
    tick = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= RATIO_1;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      // wrap only occurs on a tick, so the counter restarts with the new ratio
      if (wrap) ratio_q <= decode_sel(sel);
    end
  end

endmodule

// File: rtl/ilv_token_ring.sv
module ilv_token_ring #(
  parameter int UNITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [UNITS-1:0] token,
  output logic             wrap,
  output logic [UNITS-1:0] uclk
);

  localparam int HALF = UNITS / 2;

  // Unit k is high while the token sits in positions k .. k+HALF-1 (mod UNITS).
  function automatic logic [UNITS-1:0] unit_clocks(input logic [UNITS-1:0] tk);
    logic [UNITS-1:0] v;
    v = '0;
    for (int k = 0; k < UNITS; k++) begin
      for (int j = 0; j < HALF; j++) begin
        v[k] = v[k] | tk[(k + j) % UNITS];
      end
    end
    return v;
  endfunction

  always_comb begin
    wrap = tick & token[UNITS-1];
    uclk = unit_clocks(token);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      token <= UNITS'(1);
    end else if (tick) begin
      token <= {token[UNITS-2:0], token[UNITS-1]};
    end
  end

endmodule

// File: rtl/ilv_nov_cell.sv
module ilv_nov_cell
  import ilv_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uclk,
  input  logic [DT_W-1:0] dead_eff,
  output logic            ph_a,
  output logic            ph_b
);

  phase_st_e       st;
  logic [DT_W-1:0] cnt;
  logic [DT_W-1:0] dlim;
  logic            gap_end;

  assign gap_end = (cnt == dlim - 1'b1);
  assign ph_a    = (st == PH_A);
  assign ph_b    = (st == PH_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= PH_GAP;
      cnt  <= '0;
      dlim <= DT_W'(1);
    end else begin
      case (st)
        PH_A: if (!uclk) begin
          st   <= PH_GAP;
          cnt  <= '0;
          dlim <= dead_eff;
        end
        PH_B: if (uclk) begin
          st   <= PH_GAP;
          cnt  <= '0;
          dlim <= dead_eff;
        end
        PH_GAP: begin
          if (gap_end) st <= uclk ? PH_A : PH_B;
          else         cnt <= cnt + 1'b1;
        end
        default: st <= PH_GAP;
      endcase
    end
  end

endmodule

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
  import ilv_pkg::*;
#(
  parameter int UNITS = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       div_sel,
  input  logic [DT_W-1:0]  dead_cyc,
  output logic [UNITS-1:0] ph_a,
  output logic [UNITS-1:0] ph_b
);

  localparam int HALF = UNITS / 2;

  // Named internal events, visible to the bound checker.
  logic             tick;
  logic             wrap;
  ratio_e           ratio_q;
  logic [UNITS-1:0] token;
  logic [UNITS-1:0] uclk;
  logic [DT_W-1:0]  dead_eff;

  assign dead_eff = DT_W'(eff_dead(dead_cyc, ratio_cycles(ratio_q), HALF));

  ilv_rate_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (div_sel),
    .wrap    (wrap),
    .tick    (tick),
    .ratio_q (ratio_q)
  );

  ilv_token_ring #(.UNITS(UNITS)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .token (token),
    .wrap  (wrap),
    .uclk  (uclk)
  );

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    ilv_nov_cell #(.DT_W(DT_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .uclk     (uclk[k]),
      .dead_eff (dead_eff),
      .ph_a     (ph_a[k]),
      .ph_b     (ph_b[k])
    );
  end

endmodule

// File: rtl/ilv_phase_gen_chk.sv
module ilv_phase_gen_chk
  import ilv_pkg::*;
#(
  parameter int UNITS = 8,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UNITS-1:0] ph_a,
  input logic [UNITS-1:0] ph_b,
  input logic [UNITS-1:0] token,
  input logic             tick,
  input logic             wrap,
  input ratio_e           ratio_q
);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_a & ph_b) == '0);

  assert_token_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(token) == 1);

  assert_ratio_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));

  assert_div1_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RATIO_1) |-> tick);

  for (genvar k = 0; k < UNITS; k++) begin : g_bbm
    assert_a_after_b_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_a[k]) |-> $past(ph_b[k] == 1'b0));
    assert_b_after_a_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_b[k]) |-> $past(ph_a[k] == 1'b0));
  end

endmodule

bind ilv_phase_gen ilv_phase_gen_chk #(.UNITS(UNITS), .DT_W(DT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ph_a    (ph_a),
  .ph_b    (ph_b),
  .token   (token),
  .tick    (tick),
  .wrap    (wrap),
  .ratio_q (ratio_q)
);

// File: tb/ilv_phase_gen_test.sv
`timescale 1ns/1ps
module ilv_phase_gen_test;
  localparam int CLK_NS = 50;
  localparam int UNITS  = 8;
  localparam int DT_W   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       div_sel = 2'd0;
  logic [DT_W-1:0]  dead_cyc = 4'd1;
  logic [UNITS-1:0] ph_a;
  logic [UNITS-1:0] ph_b;

  always #(CLK_NS/2) clk = ~clk;

  ilv_phase_gen #(.UNITS(UNITS), .DT_W(DT_W)) uut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .dead_cyc(dead_cyc),
    .ph_a(ph_a), .ph_b(ph_b)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // mode 0: idle, 1: exact steady-state checks, 2: runt-only checks
  int mode = 0;
  int exp_r = 1, exp_d = 1, exp_w = 3, min_w = 1, ov_cnt = 0;
  string dtag = "R4";
  int spacing_q[$];
  bit have_prev = 0;
  int prev_unit = 0, prev_cyc = 0;
  int  wa[UNITS], wb[UNITS], lowrun[UNITS];
  bit  va[UNITS], vb[UNITS], vlow[UNITS], pa[UNITS], pb[UNITS];

  function automatic int sel_ratio(input int s);
    if (s == 0) return 1;
    if (s == 1) return 2;
    return 4;
  endfunction

  function automatic int model_dead(input int d, input int r);
    int top;
    top = (UNITS / 2) * r - 1;
    if (d < 1) return 1;
    if (d > top) return top;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act,
                       input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected rise spacings and measures gaps and widths.
  always @(negedge clk) begin
    int sp;
    if (rst_n) begin
      if ((ph_a & ph_b) != '0) ov_cnt++;
      for (int k = 0; k < UNITS; k++) begin
        // falls
        if (!ph_a[k] && pa[k] && va[k]) begin
          if (mode == 1) check(wa[k] == exp_w, "R8", wa[k], exp_w, "phase A width");
          if (mode == 2) check(wa[k] >= min_w, "R6", wa[k], min_w, "phase A runt");
        end
        if (!ph_b[k] && pb[k] && vb[k]) begin
          if (mode == 1) check(wb[k] == exp_w, "R8", wb[k], exp_w, "phase B width");
          if (mode == 2) check(wb[k] >= min_w, "R6", wb[k], min_w, "phase B runt");
        end
        // rises
        if ((ph_a[k] && !pa[k]) || (ph_b[k] && !pb[k])) begin
          if (mode == 1 && vlow[k])
            check(lowrun[k] == exp_d, dtag, lowrun[k], exp_d, "both-low gap");
        end
        if (ph_a[k] && !pa[k]) begin
          if (mode == 1) begin
            if (have_prev && spacing_q.size() > 0) begin
              sp = spacing_q.pop_front();
              check(k == (prev_unit + 1) % UNITS, "R2", k, (prev_unit + 1) % UNITS, "unit order");
              check(cyc - prev_cyc == sp, "R5", cyc - prev_cyc, sp, "rise spacing");
            end
            have_prev = 1;
            prev_unit = k;
            prev_cyc  = cyc;
          end
          wa[k] = 1; va[k] = (mode != 0);
        end else if (ph_a[k]) wa[k]++;
        if (ph_b[k] && !pb[k]) begin
          wb[k] = 1; vb[k] = (mode != 0);
        end else if (ph_b[k]) wb[k]++;
        if (!ph_a[k] && !ph_b[k]) begin
          if (pa[k] || pb[k]) begin
            lowrun[k] = 1; vlow[k] = (mode != 0);
          end else lowrun[k]++;
        end
        pa[k] = ph_a[k];
        pb[k] = ph_b[k];
      end
    end
  end

  task automatic clear_meas();
    for (int k = 0; k < UNITS; k++) begin
      va[k] = 0; vb[k] = 0; vlow[k] = 0;
    end
    have_prev = 0;
    spacing_q.delete();
    ov_cnt = 0;
  endtask

  // Driver: apply settings, let them settle, then push expected spacings.
  task automatic run_case(input int sel, input int dead, input int n, input string tag);
    @(posedge clk); #1;
    mode = 0;
    div_sel = 2'(sel);
    dead_cyc = DT_W'(dead);
    repeat (80) @(posedge clk);
    #1;
    exp_r = sel_ratio(sel);
    exp_d = model_dead(dead, exp_r);
    exp_w = (UNITS / 2) * exp_r - exp_d;
    dtag  = tag;
    clear_meas();
    for (int i = 0; i < n; i++) spacing_q.push_back(exp_r);
    mode = 1;
    while (spacing_q.size() > 0) @(posedge clk);
    repeat (UNITS * exp_r + 2) @(posedge clk);
    #1;
    mode = 0;
    check(ov_cnt == 0, "R3", ov_cnt, 0, "overlap cycles");
  endtask

  task automatic switch_case();
    @(posedge clk); #1;
    mode = 0;
    dead_cyc = DT_W'(2);
    div_sel = 2'd2;
    repeat (80) @(posedge clk);
    #1;
    min_w = (UNITS / 2) * 1 - 2;
    clear_meas();
    mode = 2;
    div_sel = 2'd0;
    repeat (60) @(posedge clk); #1;
    div_sel = 2'd1;
    repeat (60) @(posedge clk); #1;
    div_sel = 2'd2;
    repeat (60) @(posedge clk); #1;
    div_sel = 2'd0;
    repeat (60) @(posedge clk); #1;
    mode = 0;
    check(ov_cnt == 0, "R3", ov_cnt, 0, "overlap cycles during ratio switch");
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(ph_a == '0 && ph_b == '0, "R1", int'({ph_a, ph_b}), 0, "phases in reset");
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_case(0, 1, 16, "R4");
    run_case(1, 3, 16, "R4");
    run_case(2, 5, 16, "R4");
    run_case(3, 0, 16, "R7");
    run_case(0, 15, 16, "R7");
    run_case(1, 15, 16, "R7");
    run_case(2, 15, 16, "R7");
    switch_case();
    run_case(1, 2, 16, "R4");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule